// File: doc/BRIEF.md
# Amplifier Protection Shutdown Sequencer

This block decides, cycle by cycle, whether the power stage of an audio amplifier may run. It watches a power-on-reset valid flag, an active-low shutdown pin, a software shutdown request, supply undervoltage and overvoltage flags, die over-temperature and output over-current flags, and a clock-fault flag from an external detector. From these it drives the analog power enable. It also reports whether the device sits in software shutdown, requests a volume ramp when playback resumes after a clock fault, and emits one-cycle event pulses that a status block can collect.

Supply faults latch and clear only through a shutdown transition: the software request, or the shutdown pin pulled low. Thermal and current faults either latch the same way or retry on their own, as selected per fault by a configuration bit. In both modes a hold-off timer, counted in pulses of a slow `tick` input, must run out before the stage runs again. The timer keeps running through shutdown, so a quick shutdown cycle cannot shorten it. The default of 1500 ticks gives 1.5 s with a 1 kHz tick.

State codes on `seqState`: 0 reset, 1 hardware shutdown, 2 software shutdown, 3 retry wait, 4 active.

Top module: `amp_guard`

## Requirements
- R1: While `porValid` is low the block is held in reset without waiting for a clock edge. `seqState` reads 0 and every output is low. The latched faults, the hold-off timer, the captured retry-mode bits and the clock-pause memory are all cleared.
- R2: A state of 0 goes to 1 on the next clock. State 1 is held while `sdPinN` is low. From any state, `sdPinN` low moves the block to state 1 on the next clock. From state 1, `sdPinN` high moves it to state 2.
- R3: The block is blocked when any of these holds: `swShutdownReq` high, a live supply, thermal, current or clock flag, or a latched supply, thermal or current fault. From state 2 with `sdPinN` high and nothing blocking, the block moves to state 4 on the next clock, or to state 3 if the hold-off timer is running. `analogEn` can be high only in state 4, and `swShutdownState` is high exactly in state 2.
- R4: `uvloFlag` or `ovloFlag` high forces `analogEn` low in the same cycle. A supply flag seen in state 4 moves the block to state 2 and latches a supply fault. That fault keeps the block out of state 4 until `swShutdownReq` is high or the block passes through state 1.
- R5: `clkFault` high in state 4 moves the block to state 2. After it clears, the block returns to state 4, and `rampResume` pulses for one cycle in the first cycle of state 4. `rampResume` stays low on every other entry into state 4, and a shutdown transition cancels a pending resume.
- R6: An over-temperature or over-current fault in state 4 moves the block to state 2. With its retry-mode bit at 1 the block restarts by itself once the flag clears and the hold-off ends. With the bit at 0 the fault latches like a supply fault.
- R7: A thermal or current fault in state 4 loads the hold-off with `HOLD_TICKS`. The hold-off counts down by one on each cycle with `tick` high. State 4 is not re-entered until it reaches zero, in either retry mode and also after a shutdown transition. The block waits in state 3 while the hold-off runs.
- R8: `otRetryMode` and `ocRetryMode` are sampled only while in state 1. Changing them in any other state has no effect until the next pass through state 1.
- R9: The event outputs are registered and appear in the first cycle after the block leaves state 4 on a fault. When several faults arrive in the same cycle only one pulses, in the order undervoltage, overvoltage, over-temperature, over-current, clock fault. Only that winning fault latches or loads the hold-off.
- R10: `swShutdownReq` high in state 4 moves the block to state 2 with no event pulse. `sdPinN` low in state 4 moves it to state 1 with no event pulse, whatever faults are present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porValid | input | 1 | Supply valid; low is an asynchronous full reset |
| sdPinN | input | 1 | Shutdown pin, low requests hardware shutdown |
| swShutdownReq | input | 1 | Software shutdown request |
| uvloFlag | input | 1 | Supply undervoltage |
| ovloFlag | input | 1 | Supply overvoltage |
| overTempFlag | input | 1 | Die over-temperature |
| overCurrFlag | input | 1 | Output over-current |
| clkFault | input | 1 | Audio clock fault from the detector |
| otRetryMode | input | 1 | 1 = thermal fault auto-retries, 0 = latches |
| ocRetryMode | input | 1 | 1 = current fault auto-retries, 0 = latches |
| tick | input | 1 | Hold-off time base pulse |
| analogEn | output | 1 | Power stage enable |
| swShutdownState | output | 1 | High in software shutdown |
| rampResume | output | 1 | Pulse: resume playback with a volume ramp |
| evtUvlo | output | 1 | Event pulse, undervoltage |
| evtOvlo | output | 1 | Event pulse, overvoltage |
| evtOverTemp | output | 1 | Event pulse, over-temperature |
| evtOverCurr | output | 1 | Event pulse, over-current |
| evtClkFault | output | 1 | Event pulse, clock fault |
| seqState | output | 3 | Current state code |

## Verification
The state is registered, so a wrong next-state choice shows on `seqState` one cycle after the causing input, and a wrong stored fault or a short hold-off shows as a state 4 entry earlier than allowed. The bench runs a cycle-accurate model built from the requirements next to the design and compares every output in every cycle. A bad fault latch is therefore reported in the first cycle the block would restart or refuse to restart. A miscounted hold-off is reported on the tick where state 3 ends too soon or too late. A wrong priority or a missing event appears on the event pulses in the cycle after the fault.

// File: rtl/amp_guard_pkg.sv
package amp_guard_pkg;

  typedef enum logic [2:0] {
    ST_RESET      = 3'd0,
    ST_HW_OFF     = 3'd1,
    ST_SW_OFF     = 3'd2,
    ST_RETRY_WAIT = 3'd3,
    ST_ACTIVE     = 3'd4
  } seq_state_e;

  // event vector bit positions, also the precedence order (low index wins)
  localparam int NUM_EVT   = 5;
  localparam int EVT_UV    = 0;
  localparam int EVT_OV    = 1;
  localparam int EVT_OT    = 2;
  localparam int EVT_OC    = 3;
  localparam int EVT_CLK   = 4;

  // latched fault slots held in the datapath
  localparam int NUM_LATCH = 3;
  localparam int LAT_SUP   = 0;
  localparam int LAT_OT    = 1;
  localparam int LAT_OC    = 2;

  typedef struct packed {
    logic [NUM_LATCH-1:0] setLatch;
    logic                 clearLatch;
    logic                 loadHold;
    logic                 markClk;
    logic                 clearClk;
    logic                 captureCfg;
  } ctrl_strobe_t;

  typedef struct packed {
    logic [NUM_LATCH-1:0] latched;
    logic                 holdBusy;
    logic                 clkPaused;
    logic                 otRetryCfg;
    logic                 ocRetryCfg;
  } dp_status_t;

endpackage

// File: rtl/amp_guard_hold_timer.sv
module amp_guard_hold_timer #(
  parameter int HOLD_TICKS = 1500
) (
  input  logic clk,
  input  logic rstN,
  input  logic load,
  input  logic tick,
  output logic busy
);
  localparam int CNT_W = $clog2(HOLD_TICKS + 1);

  logic [CNT_W-1:0] holdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (load) begin
      holdCnt <= CNT_W'(HOLD_TICKS);
    end else if (tick && (holdCnt != '0)) begin
      holdCnt <= holdCnt - 1'b1;
    end
  end

  assign busy = (holdCnt != '0);
endmodule

// File: rtl/amp_guard_dp.sv
module amp_guard_dp
  import amp_guard_pkg::*;
#(
  parameter int HOLD_TICKS = 1500
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrl_strobe_t strobe,
  input  logic         tick,
  input  logic         otRetryMode,
  input  logic         ocRetryMode,
  output dp_status_t   status
);
  logic [NUM_LATCH-1:0] latchVec;
  logic                 holdBusy;
  logic                 clkPausedQ;
  logic                 otCfgQ;
  logic                 ocCfgQ;

  // one sticky fault bit per slot; a set beats a clear in the same cycle
  for (genvar i = 0; i < NUM_LATCH; i++) begin : g_latch
    logic faultQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        faultQ <= 1'b0;
      end else if (strobe.setLatch[i]) begin
        faultQ <= 1'b1;
      end else if (strobe.clearLatch) begin
        faultQ <= 1'b0;
      end
    end
    assign latchVec[i] = faultQ;
  end

  amp_guard_hold_timer #(
    .HOLD_TICKS(HOLD_TICKS)
  ) u_hold (
    .clk  (clk),
    .rstN (rstN),
    .load (strobe.loadHold),
    .tick (tick),
    .busy (holdBusy)
  );

  // memory of a clock-fault stop, used to request a ramped resume
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPausedQ <= 1'b0;
    end else if (strobe.markClk) begin
      clkPausedQ <= 1'b1;
    end else if (strobe.clearLatch || strobe.clearClk) begin
      clkPausedQ <= 1'b0;
    end
  end

  // retry-mode configuration, frozen outside hardware shutdown
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      otCfgQ <= 1'b0;
      ocCfgQ <= 1'b0;
    end else if (strobe.captureCfg) begin
      otCfgQ <= otRetryMode;
      ocCfgQ <= ocRetryMode;
    end
  end

  assign status.latched    = latchVec;
  assign status.holdBusy   = holdBusy;
  assign status.clkPaused  = clkPausedQ;
  assign status.otRetryCfg = otCfgQ;
  assign status.ocRetryCfg = ocCfgQ;
endmodule

// File: rtl/amp_guard_ctrl.sv
module amp_guard_ctrl
  import amp_guard_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               sdPinN,
  input  logic               swReq,
  input  logic               uvlo,
  input  logic               ovlo,
  input  logic               overTemp,
  input  logic               overCurr,
  input  logic               clkFault,
  input  dp_status_t         status,
  output seq_state_e         state,
  output ctrl_strobe_t       strobe,
  output logic [NUM_EVT-1:0] evtVec,
  output logic               rampResume
);
  seq_state_e         nextState;
  logic [NUM_EVT-1:0] evtNext;
  logic               eligible;
  logic               goActive;

  always_comb begin
    eligible = !swReq && !uvlo && !ovlo && !overTemp && !overCurr &&
               !clkFault && (status.latched == '0);
  end

  always_comb begin
    nextState         = state;
    evtNext           = '0;
    strobe            = '0;
    strobe.clearLatch = (state != ST_RESET) && (swReq || (state == ST_HW_OFF));
    strobe.captureCfg = (state == ST_HW_OFF);
    unique case (state)
      ST_RESET: nextState = ST_HW_OFF;
      ST_HW_OFF: begin
        if (sdPinN) nextState = ST_SW_OFF;
      end
      ST_SW_OFF: begin
        if (!sdPinN)       nextState = ST_HW_OFF;
        else if (eligible) nextState = status.holdBusy ? ST_RETRY_WAIT : ST_ACTIVE;
      end
      ST_RETRY_WAIT: begin
        if (!sdPinN)               nextState = ST_HW_OFF;
        else if (!eligible)        nextState = ST_SW_OFF;
        else if (!status.holdBusy) nextState = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (!sdPinN) begin
          nextState = ST_HW_OFF;
        end else if (uvlo) begin
          nextState                = ST_SW_OFF;
          strobe.setLatch[LAT_SUP] = 1'b1;
          evtNext[EVT_UV]          = 1'b1;
        end else if (ovlo) begin
          nextState                = ST_SW_OFF;
          strobe.setLatch[LAT_SUP] = 1'b1;
          evtNext[EVT_OV]          = 1'b1;
        end else if (overTemp) begin
          nextState               = ST_SW_OFF;
          strobe.loadHold         = 1'b1;
          strobe.setLatch[LAT_OT] = !status.otRetryCfg;
          evtNext[EVT_OT]         = 1'b1;
        end else if (overCurr) begin
          nextState               = ST_SW_OFF;
          strobe.loadHold         = 1'b1;
          strobe.setLatch[LAT_OC] = !status.ocRetryCfg;
          evtNext[EVT_OC]         = 1'b1;
        end else if (clkFault) begin
          nextState        = ST_SW_OFF;
          strobe.markClk   = 1'b1;
          evtNext[EVT_CLK] = 1'b1;
        end else if (swReq) begin
          nextState = ST_SW_OFF;
        end
      end
      default: nextState = ST_RESET;
    endcase
    goActive        = (nextState == ST_ACTIVE) && (state != ST_ACTIVE);
    strobe.clearClk = goActive;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_RESET;
      evtVec     <= '0;
      rampResume <= 1'b0;
    end else begin
      state      <= nextState;
      evtVec     <= evtNext;
      rampResume <= goActive && status.clkPaused;
    end
  end
endmodule

// File: rtl/amp_guard.sv
module amp_guard
  import amp_guard_pkg::*;
#(
  parameter int HOLD_TICKS = 1500
) (
  input  logic       clk,
  input  logic       porValid,
  input  logic       sdPinN,
  input  logic       swShutdownReq,
  input  logic       uvloFlag,
  input  logic       ovloFlag,
  input  logic       overTempFlag,
  input  logic       overCurrFlag,
  input  logic       clkFault,
  input  logic       otRetryMode,
  input  logic       ocRetryMode,
  input  logic       tick,
  output logic       analogEn,
  output logic       swShutdownState,
  output logic       rampResume,
  output logic       evtUvlo,
  output logic       evtOvlo,
  output logic       evtOverTemp,
  output logic       evtOverCurr,
  output logic       evtClkFault,
  output logic [2:0] seqState
);
  ctrl_strobe_t       strobe;
  dp_status_t         status;
  seq_state_e         state;
  logic [NUM_EVT-1:0] evtVec;

  amp_guard_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (porValid),
    .sdPinN     (sdPinN),
    .swReq      (swShutdownReq),
    .uvlo       (uvloFlag),
    .ovlo       (ovloFlag),
    .overTemp   (overTempFlag),
    .overCurr   (overCurrFlag),
    .clkFault   (clkFault),
    .status     (status),
    .state      (state),
    .strobe     (strobe),
    .evtVec     (evtVec),
    .rampResume (rampResume)
  );

  amp_guard_dp #(
    .HOLD_TICKS(HOLD_TICKS)
  ) u_dp (
    .clk         (clk),
    .rstN        (porValid),
    .strobe      (strobe),
    .tick        (tick),
    .otRetryMode (otRetryMode),
    .ocRetryMode (ocRetryMode),
    .status      (status)
  );

  // supply faults gate the stage combinationally, without waiting a cycle
  assign analogEn        = (state == ST_ACTIVE) && !uvloFlag && !ovloFlag;
  assign swShutdownState = (state == ST_SW_OFF);
  assign seqState        = state;
  assign evtUvlo         = evtVec[EVT_UV];
  assign evtOvlo         = evtVec[EVT_OV];
  assign evtOverTemp     = evtVec[EVT_OT];
  assign evtOverCurr     = evtVec[EVT_OC];
  assign evtClkFault     = evtVec[EVT_CLK];
endmodule

// File: rtl/amp_guard_chk.sv
module amp_guard_chk (
  input logic       clk,
  input logic       porValid,
  input logic       sdPinN,
  input logic       swShutdownReq,
  input logic       uvloFlag,
  input logic       ovloFlag,
  input logic       analogEn,
  input logic       rampResume,
  input logic       evtUvlo,
  input logic       evtOvlo,
  input logic       evtOverTemp,
  input logic       evtOverCurr,
  input logic       evtClkFault,
  input logic [2:0] seqState
);
  assert_reset_exit_R1: assert property (@(posedge clk) disable iff (!porValid)
    (seqState == 3'd0) |=> (seqState == 3'd1));

  assert_pin_forces_hw_R2: assert property (@(posedge clk) disable iff (!porValid)
    !sdPinN |=> (seqState == 3'd1));

  assert_enable_only_active_R3: assert property (@(posedge clk) disable iff (!porValid)
    analogEn |-> (seqState == 3'd4));

  assert_supply_cut_R4: assert property (@(posedge clk) disable iff (!porValid)
    (uvloFlag || ovloFlag) |-> !analogEn);

  assert_ramp_on_entry_R5: assert property (@(posedge clk) disable iff (!porValid)
    rampResume |-> ((seqState == 3'd4) && ($past(seqState) != 3'd4)));

  assert_single_event_R9: assert property (@(posedge clk) disable iff (!porValid)
    $onehot0({evtClkFault, evtOverCurr, evtOverTemp, evtOvlo, evtUvlo}));

  assert_sw_request_stops_R10: assert property (@(posedge clk) disable iff (!porValid)
    swShutdownReq |=> (seqState != 3'd4));
endmodule

bind amp_guard amp_guard_chk u_chk (
  .clk           (clk),
  .porValid      (porValid),
  .sdPinN        (sdPinN),
  .swShutdownReq (swShutdownReq),
  .uvloFlag      (uvloFlag),
  .ovloFlag      (ovloFlag),
  .analogEn      (analogEn),
  .rampResume    (rampResume),
  .evtUvlo       (evtUvlo),
  .evtOvlo       (evtOvlo),
  .evtOverTemp   (evtOverTemp),
  .evtOverCurr   (evtOverCurr),
  .evtClkFault   (evtClkFault),
  .seqState      (seqState)
);

// File: tb/tb_amp_guard.sv
`timescale 1ns/1ps
module tb_amp_guard;
  localparam int HOLD = 5;

  logic clk = 1'b0;
  logic porValid = 1'b0, sdPinN = 1'b0, swShutdownReq = 1'b0;
  logic uvloFlag = 1'b0, ovloFlag = 1'b0, overTempFlag = 1'b0, overCurrFlag = 1'b0;
  logic clkFault = 1'b0, otRetryMode = 1'b0, ocRetryMode = 1'b0, tick = 1'b0;
  logic analogEn, swShutdownState, rampResume;
  logic evtUvlo, evtOvlo, evtOverTemp, evtOverCurr, evtClkFault;
  logic [2:0] seqState;

  always #2.5 clk = ~clk;

  amp_guard #(.HOLD_TICKS(HOLD)) dut (
    .clk(clk), .porValid(porValid), .sdPinN(sdPinN), .swShutdownReq(swShutdownReq),
    .uvloFlag(uvloFlag), .ovloFlag(ovloFlag), .overTempFlag(overTempFlag),
    .overCurrFlag(overCurrFlag), .clkFault(clkFault), .otRetryMode(otRetryMode),
    .ocRetryMode(ocRetryMode), .tick(tick), .analogEn(analogEn),
    .swShutdownState(swShutdownState), .rampResume(rampResume), .evtUvlo(evtUvlo),
    .evtOvlo(evtOvlo), .evtOverTemp(evtOverTemp), .evtOverCurr(evtOverCurr),
    .evtClkFault(evtClkFault), .seqState(seqState)
  );

  int nChecks = 0;
  int nFail = 0;

  // reference model, written from the requirements
  int   mSt = 0;
  int   mCnt = 0;
  logic mSup = 0, mOt = 0, mOc = 0, mClk = 0, mCfgOt = 0, mCfgOc = 0, mRamp = 0;
  logic [4:0] mEvt = '0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int expAnalog();
    return (porValid && mSt == 4 && !uvloFlag && !ovloFlag) ? 1 : 0;
  endfunction

  task automatic modelStep();
    int   nxt;
    logic elig, busy, ld, sSup, sOt, sOc, mk, clr, ramp;
    logic [4:0] e;
    if (!porValid) begin
      mSt = 0; mCnt = 0; mSup = 0; mOt = 0; mOc = 0; mClk = 0;
      mCfgOt = 0; mCfgOc = 0; mRamp = 0; mEvt = '0;
      return;
    end
    busy = (mCnt != 0);
    elig = !swShutdownReq && !uvloFlag && !ovloFlag && !overTempFlag && !overCurrFlag &&
           !clkFault && !mSup && !mOt && !mOc;
    nxt = mSt; ld = 0; sSup = 0; sOt = 0; sOc = 0; mk = 0; e = '0;
    case (mSt)
      0: nxt = 1;
      1: nxt = sdPinN ? 2 : 1;
      2: if (!sdPinN) nxt = 1; else if (elig) nxt = busy ? 3 : 4;
      3: if (!sdPinN) nxt = 1; else if (!elig) nxt = 2; else if (!busy) nxt = 4;
      default: begin
        if (!sdPinN) nxt = 1;
        else if (uvloFlag)     begin nxt = 2; sSup = 1; e[0] = 1; end
        else if (ovloFlag)     begin nxt = 2; sSup = 1; e[1] = 1; end
        else if (overTempFlag) begin nxt = 2; ld = 1; sOt = !mCfgOt; e[2] = 1; end
        else if (overCurrFlag) begin nxt = 2; ld = 1; sOc = !mCfgOc; e[3] = 1; end
        else if (clkFault)     begin nxt = 2; mk = 1; e[4] = 1; end
        else if (swShutdownReq) nxt = 2;
      end
    endcase
    clr  = swShutdownReq || (mSt == 1);
    ramp = (nxt == 4) && (mSt != 4) && mClk;
    mSup = sSup ? 1'b1 : (clr ? 1'b0 : mSup);
    mOt  = sOt  ? 1'b1 : (clr ? 1'b0 : mOt);
    mOc  = sOc  ? 1'b1 : (clr ? 1'b0 : mOc);
    mClk = mk ? 1'b1 : ((clr || (nxt == 4 && mSt != 4)) ? 1'b0 : mClk);
    if (ld) mCnt = HOLD;
    else if (tick && mCnt != 0) mCnt = mCnt - 1;
    if (mSt == 1) begin mCfgOt = otRetryMode; mCfgOc = ocRetryMode; end
    mEvt = e; mRamp = ramp; mSt = nxt;
  endtask

  // called at a falling edge with the inputs for the coming cycles applied
  task automatic step(input string tag, input int n = 1);
    for (int k = 0; k < n; k++) begin
      #1;
      chk(tag, "analogEn", int'(analogEn), expAnalog());
      modelStep();
      @(negedge clk);
      chk(tag, "seqState", int'(seqState), mSt);
      chk(tag, "swShutdownState", int'(swShutdownState), (mSt == 2) ? 1 : 0);
      chk(tag, "events", int'({evtClkFault, evtOverCurr, evtOverTemp, evtOvlo, evtUvlo}), int'(mEvt));
      chk(tag, "rampResume", int'(rampResume), int'(mRamp));
    end
  endtask

  task automatic quiet();
    swShutdownReq = 0; uvloFlag = 0; ovloFlag = 0; overTempFlag = 0;
    overCurrFlag = 0; clkFault = 0; tick = 0;
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: run still going, got 0 expected 1");
    finishRun();
  end

  initial begin
    @(negedge clk);
    // R1: held in reset
    step("R1", 3);
    chk("R1", "reset state", int'(seqState), 0);
    // R2: leave reset into hardware shutdown, hold while pin low, capture config
    porValid = 1; otRetryMode = 1; ocRetryMode = 0;
    step("R2", 4);
    chk("R2", "hw shutdown", int'(seqState), 1);
    sdPinN = 1;
    step("R3", 3);
    chk("R3", "active", int'(seqState), 4);
    // R4: undervoltage latches, cleared by a software request
    uvloFlag = 1; #1;
    chk("R4", "immediate cut", int'(analogEn), 0);
    step("R4");
    uvloFlag = 0;
    step("R4", 4);
    chk("R4", "held off", int'(seqState), 2);
    swShutdownReq = 1; step("R4");
    swShutdownReq = 0; step("R4", 2);
    chk("R4", "restart", int'(seqState), 4);
    // R4: overvoltage cleared by a hardware shutdown pass
    ovloFlag = 1; step("R4");
    ovloFlag = 0; step("R4", 3);
    sdPinN = 0; step("R2");
    sdPinN = 1; step("R4", 3);
    chk("R4", "restart after pin", int'(seqState), 4);
    // R5: clock fault pause and ramped resume
    clkFault = 1; step("R5", 3);
    clkFault = 0; step("R5");
    chk("R5", "ramp pulse", int'(rampResume), 1);
    step("R5");
    chk("R5", "ramp one cycle", int'(rampResume), 0);
    // R6, R7: auto-retry thermal fault honours the hold-off
    overTempFlag = 1; step("R6");
    overTempFlag = 0; tick = 1; step("R7", 3);
    chk("R7", "retry wait", int'(seqState), 3);
    step("R7", 4);
    chk("R6", "auto restart", int'(seqState), 4);
    // R6: latched current fault
    overCurrFlag = 1; tick = 0; step("R6");
    overCurrFlag = 0; tick = 1; step("R6", 8);
    chk("R6", "latched", int'(seqState), 2);
    swShutdownReq = 1; step("R6");
    swShutdownReq = 0; step("R6", 2);
    chk("R6", "after clear", int'(seqState), 4);
    // R7: shutdown cycle does not shorten the hold-off
    overCurrFlag = 1; tick = 0; step("R7");
    overCurrFlag = 0; swShutdownReq = 1; step("R7");
    swShutdownReq = 0; step("R7", 4);
    chk("R7", "wait after shutdown", int'(seqState), 3);
    tick = 1; step("R7", 7);
    chk("R7", "resumed", int'(seqState), 4);
    // R8: config change outside hardware shutdown has no effect
    tick = 0; ocRetryMode = 1;
    overCurrFlag = 1; step("R8");
    overCurrFlag = 0; tick = 1; step("R8", 9);
    chk("R8", "still latched", int'(seqState), 2);
    swShutdownReq = 1; step("R8");
    quiet(); step("R8", 2);
    // R9: precedence among simultaneous faults
    uvloFlag = 1; overTempFlag = 1; clkFault = 1; step("R9");
    chk("R9", "uv wins", int'(evtUvlo), 1);
    quiet(); swShutdownReq = 1; step("R9");
    swShutdownReq = 0; step("R9", 2);
    overTempFlag = 1; overCurrFlag = 1; step("R9");
    chk("R9", "ot wins", int'(evtOverTemp), 1);
    quiet(); tick = 1; step("R9", 8);
    // R10: pin low with a fault gives no event; software request gives none
    tick = 0; overTempFlag = 1; sdPinN = 0; step("R10");
    chk("R10", "no event on pin", int'(evtOverTemp), 0);
    quiet(); sdPinN = 1; step("R10", 3);
    swShutdownReq = 1; step("R10");
    chk("R10", "sw state", int'(swShutdownState), 1);
    quiet(); step("R10", 2);

    // mixed random stimulus with a fixed seed
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4000; i++) begin
      porValid      = ($urandom_range(0, 299) != 0);
      sdPinN        = ($urandom_range(0, 39) != 0);
      swShutdownReq = ($urandom_range(0, 24) == 0);
      uvloFlag      = ($urandom_range(0, 39) == 0);
      ovloFlag      = ($urandom_range(0, 39) == 0);
      overTempFlag  = ($urandom_range(0, 29) == 0);
      overCurrFlag  = ($urandom_range(0, 29) == 0);
      clkFault      = ($urandom_range(0, 19) == 0);
      otRetryMode   = $urandom_range(0, 1) != 0;
      ocRetryMode   = $urandom_range(0, 1) != 0;
      tick          = $urandom_range(0, 1) != 0;
      step("R3");
    end
    finishRun();
  end
endmodule